// File: doc/BRIEF.md
# Power-on memory shadowing controller

This block sits between a fast internal processor core and a slow external host bus in a socket-replacement accelerator. After reset it stalls the core and copies the host's whole address space into the on-chip RAM, one byte per external read. Pages that the selected memory map marks as I/O are never read. When the copy is complete, the stall is released. From then on every core access is steered by address. Memory pages are served from the internal RAM with no external traffic. I/O pages are forwarded to an external bus-cycle engine through a request/acknowledge handshake, and the core waits until that engine answers.

The address space is divided into pages of 2^OFF_W bytes. A 4-bit static switch chooses one of 16 memory maps, and the controller captures the switch once, in the first cycle after reset is released. The internal RAM sits outside the block on a simple synchronous port with one cycle of read latency. The bus-cycle engine runs from the host's own clock, so the number of wait cycles on every external transfer is set by its acknowledge.

Top module: `shadow_ctrl`

## Requirements
- R1: While rst_ni is low: core_stall_o=1, copy_done_o=0, ext_req_o=0 and ram_we_o=0.
- R2: The copy visits addresses in ascending order starting at 0. For each byte in a memory page it issues one external read (ext_we_o=0) at that address. In the cycle the acknowledge arrives it writes ext_rdata_i to the RAM at the same address. A cycle with no acknowledge produces no RAM write.
- R3: During the copy, ext_req_o is never high with ext_addr_o inside an I/O page. RAM locations in I/O pages are not written by the copy.
- R4: Map encoding: page p (p = address >> OFF_W) is I/O under switch value m when the two top bits of p are both 1 and bit p[1:0] of m is 1. The switch is captured in the first cycle after reset is released. Later changes to the switch have no effect.
- R5: Each skipped I/O page costs one cycle. copy_done_o rises in the cycle after the final step of the copy: the last byte write, or the skip of a trailing I/O page. It stays high until reset. core_stall_o falls one cycle after copy_done_o rises.
- R6: After the copy, a core access to a memory page is accepted in the cycle it is presented, with core_stall_o=0 and no external request. A write reaches the RAM in that cycle. Read data appears on core_rdata_o in the next cycle.
- R7: After the copy, a core access to an I/O page drives ext_req_o with the core's address, write flag and write data, and never writes the RAM. core_stall_o stays high until ext_ack_i arrives. In the acknowledge cycle, core_rdata_o equals ext_rdata_i.
- R8: A reset during the copy restarts it at address 0, using the switch value present after the new reset is released.
- R9: Core requests made while the copy is running are held off by core_stall_o=1 and do not disturb the copy's RAM writes. A request held through the copy is accepted in the first cycle that core_stall_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| map_sel_i | input | 4 | Static memory-map switch |
| core_req_i | input | 1 | Core access request, held while stalled |
| core_we_i | input | 1 | Core write flag |
| core_addr_i | input | ADDR_W | Core address |
| core_wdata_i | input | DATA_W | Core write data |
| core_rdata_o | output | DATA_W | Read data to the core |
| core_stall_o | output | 1 | Core must hold its request |
| copy_done_o | output | 1 | Shadow copy complete |
| ext_req_o | output | 1 | Request to the external bus engine |
| ext_we_o | output | 1 | External write flag |
| ext_addr_o | output | ADDR_W | External address |
| ext_wdata_o | output | DATA_W | External write data |
| ext_ack_i | input | 1 | Engine acknowledge, one cycle per transfer |
| ext_rdata_i | input | DATA_W | External read data, valid with the acknowledge |
| ram_we_o | output | 1 | Internal RAM write enable |
| ram_addr_o | output | ADDR_W | Internal RAM address |
| ram_wdata_o | output | DATA_W | Internal RAM write data |
| ram_rdata_i | input | DATA_W | Internal RAM read data, one cycle after the address |

## Verification
Two things can land in the same cycle: the copy's final RAM write and a core request that is waiting on the stall. The bench provokes this by holding a core read from before reset release through the whole copy. The RAM write log must show only copy-sequence addresses and data. The held read must be accepted exactly in the first unstalled cycle and return the host byte. Trailing I/O pages are covered with switch values that set bit 3, which moves done away from the last write by the number of skipped pages.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned SEL_W = 4;

  typedef enum logic [1:0] {ST_SAMPLE, ST_COPY, ST_DONE} seq_state_e;

  // Pages in the top quarter are I/O when the sel bit picked by page[1:0] is set
  function automatic logic page_is_io(input logic [SEL_W-1:0] sel,
                                      input logic [15:0] page,
                                      input int unsigned page_w);
    logic [15:0] top;
    top = page >> (page_w - 2);
    return (top[1:0] == 2'b11) && sel[page[1:0]];
  endfunction
endpackage

// File: rtl/shadow_map_table.sv
module shadow_map_table
  import shadow_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned NPORT  = 2
) (
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [NPORT-1:0][PAGE_W-1:0] page_i,
  output logic [NPORT-1:0]             io_o
);
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign io_o[g] = page_is_io(sel_i, 16'(page_i[g]), PAGE_W);
  end
endmodule

// File: rtl/shadow_copy_seq.sv
module shadow_copy_seq
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sw_i,
  output logic [SEL_W-1:0]  sel_o,
  input  logic              page_io_i,
  output logic              ext_req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              ext_ack_i,
  output logic              ram_we_o,
  output logic              done_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SEL_W-1:0]  sel_q;
  logic [PAGE_W-1:0] page;
  logic              last_page;

  assign page      = addr_q[ADDR_W-1:OFF_W];
  assign last_page = &page;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SAMPLE;
      addr_q  <= '0;
      sel_q   <= '0;
    end else begin
      unique case (state_q)
        ST_SAMPLE: begin
          sel_q   <= sw_i;
          addr_q  <= '0;
          state_q <= ST_COPY;
        end
        ST_COPY: begin
          if (page_io_i) begin
            if (last_page) state_q <= ST_DONE;
            else           addr_q  <= {page + PAGE_W'(1), {OFF_W{1'b0}}};
          end else if (ext_ack_i) begin
            if (&addr_q) state_q <= ST_DONE;
            else         addr_q  <= addr_q + ADDR_W'(1);
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign ext_req_o = (state_q == ST_COPY) && !page_io_i;
  assign ram_we_o  = ext_req_o && ext_ack_i;
  assign done_o    = (state_q == ST_DONE);
  assign addr_o    = addr_q;
  assign sel_o     = sel_q;
endmodule

// File: rtl/shadow_router.sv
module shadow_router #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              run_i,
  input  logic              core_req_i,
  input  logic              core_we_i,
  input  logic              core_io_i,
  output logic [DATA_W-1:0] core_rdata_o,
  output logic              core_stall_o,
  output logic              ext_req_o,
  input  logic              ext_ack_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              ram_we_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic io_done;

  assign ext_req_o    = run_i && core_req_i && core_io_i;
  assign io_done      = ext_req_o && ext_ack_i;
  assign ram_we_o     = run_i && core_req_i && !core_io_i && core_we_i;
  assign core_stall_o = !run_i || (ext_req_o && !ext_ack_i);
  assign core_rdata_o = io_done ? ext_rdata_i : ram_rdata_i;
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        map_sel_i,
  input  logic              core_req_i,
  input  logic              core_we_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic [DATA_W-1:0] core_rdata_o,
  output logic              core_stall_o,
  output logic              copy_done_o,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic              ext_ack_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic [SEL_W-1:0]       map_sel_q;
  logic [1:0][PAGE_W-1:0] lookup_page;
  logic [1:0]             lookup_io;
  logic [ADDR_W-1:0]      seq_addr;
  logic                   seq_req, seq_we, seq_done;
  logic                   rtr_req, rtr_we;
  logic                   run_q;

  assign lookup_page[0] = seq_addr[ADDR_W-1:OFF_W];
  assign lookup_page[1] = core_addr_i[ADDR_W-1:OFF_W];

  shadow_map_table #(.PAGE_W(PAGE_W), .NPORT(2)) u_map (
    .sel_i (map_sel_q),
    .page_i(lookup_page),
    .io_o  (lookup_io)
  );

  shadow_copy_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_i     (map_sel_i),
    .sel_o    (map_sel_q),
    .page_io_i(lookup_io[0]),
    .ext_req_o(seq_req),
    .addr_o   (seq_addr),
    .ext_ack_i(ext_ack_i),
    .ram_we_o (seq_we),
    .done_o   (seq_done)
  );

  // Stall drops one cycle after done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= seq_done;
  end

  shadow_router #(.DATA_W(DATA_W)) u_rtr (
    .run_i       (run_q),
    .core_req_i  (core_req_i),
    .core_we_i   (core_we_i),
    .core_io_i   (lookup_io[1]),
    .core_rdata_o(core_rdata_o),
    .core_stall_o(core_stall_o),
    .ext_req_o   (rtr_req),
    .ext_ack_i   (ext_ack_i),
    .ext_rdata_i (ext_rdata_i),
    .ram_we_o    (rtr_we),
    .ram_rdata_i (ram_rdata_i)
  );

  assign copy_done_o = seq_done;
  assign ext_req_o   = seq_req || rtr_req;
  assign ext_we_o    = run_q && core_we_i;
  assign ext_addr_o  = run_q ? core_addr_i : seq_addr;
  assign ext_wdata_o = core_wdata_i;
  assign ram_we_o    = seq_we || rtr_we;
  assign ram_addr_o  = run_q ? core_addr_i : seq_addr;
  assign ram_wdata_o = run_q ? core_wdata_i : ext_rdata_i;
endmodule

// File: rtl/shadow_ctrl_chk.sv
module shadow_ctrl_chk
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  sel_i,
  input logic              stall_i,
  input logic              done_i,
  input logic              ext_req_i,
  input logic              ext_we_i,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic              ext_ack_i,
  input logic              ram_we_i,
  input logic [ADDR_W-1:0] ram_addr_i,
  input logic              core_req_i,
  input logic [ADDR_W-1:0] core_addr_i
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic ext_io, core_io;
  assign ext_io  = page_is_io(sel_i, 16'(ext_addr_i[ADDR_W-1:OFF_W]), PAGE_W);
  assign core_io = page_is_io(sel_i, 16'(core_addr_i[ADDR_W-1:OFF_W]), PAGE_W);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_STATE: assert (stall_i && !done_i && !ext_req_i && !ram_we_i); // R1
    end
  end

  AST_COPY_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && ext_req_i) |-> !ext_we_i); // R2

  AST_COPY_WR_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && ram_we_i) |-> (ext_ack_i && ext_req_i && ram_addr_i == ext_addr_i)); // R2

  AST_COPY_SKIPS_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && ext_req_i) |-> !ext_io); // R3

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i); // R5

  AST_STALL_ON_DONE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> stall_i); // R5

  AST_MEM_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && $past(done_i) && !(core_req_i && core_io)) |-> !stall_i); // R6

  AST_IO_NOT_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && core_req_i && core_io) |-> !ram_we_i); // R7

  AST_STALL_DURING_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> stall_i); // R9
endmodule

bind shadow_ctrl shadow_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (map_sel_q),
  .stall_i    (core_stall_o),
  .done_i     (copy_done_o),
  .ext_req_i  (ext_req_o),
  .ext_we_i   (ext_we_o),
  .ext_addr_i (ext_addr_o),
  .ext_ack_i  (ext_ack_i),
  .ram_we_i   (ram_we_o),
  .ram_addr_i (ram_addr_o),
  .core_req_i (core_req_i),
  .core_addr_i(core_addr_i)
);

// File: tb/shadow_ctrl_bench.sv
module shadow_ctrl_bench;
  localparam int AW = 8;
  localparam int OW = 4;
  localparam int DW = 8;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    sw_in = 4'h0;
  logic          core_req = 1'b0, core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic [DW-1:0] core_rdata;
  logic          stall, done;
  logic          ext_req, ext_we;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata;
  logic          ext_ack = 1'b0;
  logic [DW-1:0] ext_rdata = '0;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;

  always #10 clk = ~clk;

  shadow_ctrl #(.ADDR_W(AW), .OFF_W(OW), .DATA_W(DW)) u_shadow_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .map_sel_i(sw_in),
    .core_req_i(core_req), .core_we_i(core_we), .core_addr_i(core_addr),
    .core_wdata_i(core_wdata), .core_rdata_o(core_rdata), .core_stall_o(stall),
    .copy_done_o(done), .ext_req_o(ext_req), .ext_we_o(ext_we),
    .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata), .ext_ack_i(ext_ack),
    .ext_rdata_i(ext_rdata), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [3:0] cur_sw = 4'h0;
  int dly = 0;
  int cyc = 0;

  function automatic logic is_io(input logic [3:0] m, input int a);
    int pg;
    pg = a >> OW;
    return (pg >= 12) && m[pg - 12];
  endfunction
  function automatic logic [7:0] host_byte(input int a);
    return 8'((a * 7 + 3) & 8'hFF);
  endfunction
  function automatic logic [7:0] io_byte(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction
  function automatic int next_mem(input logic [3:0] m, input int a);
    int x;
    x = a;
    while (x < NB && is_io(m, x)) x++;
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // internal RAM model
  logic fill = 1'b0;
  logic [DW-1:0] mem [NB];
  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hEE;
    end else begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  // external bus engine
  int eng_cnt = 0, ext_txn = 0;
  logic [AW-1:0] wr_log_addr = '0;
  logic [DW-1:0] wr_log_data = '0;
  int wr_log_cnt = 0;
  always @(posedge clk) begin
    cyc++;
    #1;
    if (!rst_n) begin
      ext_ack = 1'b0; eng_cnt = 0;
    end else if (ext_ack) begin
      ext_ack = 1'b0;
    end else if (ext_req) begin
      if (eng_cnt >= dly) begin
        ext_ack = 1'b1; eng_cnt = 0; ext_txn++;
        ext_rdata = is_io(cur_sw, int'(ext_addr)) ? io_byte(int'(ext_addr)) : host_byte(int'(ext_addr));
        if (ext_we) begin
          wr_log_addr = ext_addr; wr_log_data = ext_wdata; wr_log_cnt++;
        end
      end else eng_cnt++;
    end
  end

  // copy monitor
  int exp_next = 0, mon_err = 0, mon_io_err = 0, wr_seen = 0, last_wr = 0;
  int done_cyc = 0, stall_cyc = 0, first_addr = -1;
  logic done_seen = 1'b0, stall_seen = 1'b0;
  always begin
    @(negedge clk); #3;
    if (rst_n) begin
      if (ext_req && !done && first_addr < 0) first_addr = int'(ext_addr);
      if (ext_req && !done && is_io(cur_sw, int'(ext_addr))) mon_io_err++;
      if (ram_we && !done) begin
        if (int'(ram_addr) != exp_next || ram_wdata !== host_byte(exp_next)) mon_err++;
        wr_seen++; last_wr = cyc;
        exp_next = next_mem(cur_sw, exp_next + 1);
      end
      if (done && !done_seen) begin done_seen = 1'b1; done_cyc = cyc; end
      if (done_seen && !stall && !stall_seen) begin stall_seen = 1'b1; stall_cyc = cyc; end
    end
  end

  task automatic start_copy(input logic [3:0] sw, input logic [3:0] late_sw);
    @(negedge clk);
    rst_n = 1'b0; fill = 1'b1; sw_in = sw; cur_sw = sw;
    @(negedge clk); fill = 1'b0;
    exp_next = next_mem(sw, 0); mon_err = 0; mon_io_err = 0; wr_seen = 0;
    done_seen = 1'b0; stall_seen = 1'b0; first_addr = -1; last_wr = 0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk); sw_in = late_sw;
  endtask

  task automatic finish_copy(input string tag);
    int t, tr, nexp, bad;
    t = 0;
    while (!(done_seen && stall_seen) && t < 5000) begin @(negedge clk); #5; t++; end
    tr = 0;
    for (int p = 15; p >= 0 && is_io(cur_sw, p << OW); p--) tr++;
    nexp = 0; bad = 0;
    for (int a = 0; a < NB; a++) begin
      if (!is_io(cur_sw, a)) nexp++;
      if (mem[a] !== (is_io(cur_sw, a) ? 8'hEE : host_byte(a))) bad++;
    end
    chk({"R2 order/data ", tag}, mon_err, 0);
    chk({"R2 write count ", tag}, wr_seen, nexp);
    chk({"R3 io read ", tag}, mon_io_err, 0);
    chk({"R4 ram image ", tag}, bad, 0);
    chk({"R5 done cycle ", tag}, done_cyc, last_wr + 1 + tr);
    chk({"R5 stall release ", tag}, stall_cyc, done_cyc + 1);
  endtask

  // returns read data: ack-cycle data for I/O, next-cycle data for memory
  task automatic access(input logic we, input int a, input logic [7:0] wd,
                        output logic [7:0] rd, output int nst);
    core_req = 1'b1; core_we = we; core_addr = AW'(a); core_wdata = wd;
    #1; nst = 0;
    while (stall && nst < 100000) begin @(negedge clk); #1; nst++; end
    rd = core_rdata;
    @(negedge clk);
    if (!is_io(cur_sw, a)) rd = core_rdata;
    core_req = 1'b0; core_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); @(negedge clk);
    chk("R1 stall in reset", stall, 1'b1);
    chk("R1 done in reset", done, 1'b0);
    chk("R1 ext_req in reset", ext_req, 1'b0);
    chk("R1 ram_we in reset", ram_we, 1'b0);
  endtask

  task automatic t_copy_maps;
    dly = 0; start_copy(4'b0101, 4'b1010); finish_copy("sw5 late-change R4");
    dly = 1; start_copy(4'b1000, 4'b0111); finish_copy("sw8 trailing io");
    dly = 0; start_copy(4'b1111, 4'b0000); finish_copy("sw15");
  endtask

  task automatic t_restart;
    dly = 0;
    start_copy(4'b0101, 4'b0101);
    repeat (60) @(negedge clk);
    start_copy(4'b0011, 4'b1100);
    finish_copy("R8 restart");
    chk("R8 first read address", first_addr, 0);
  endtask

  task automatic t_collision;
    logic [7:0] rd; int nst;
    dly = 0;
    @(negedge clk);
    core_req = 1'b1; core_we = 1'b0; core_addr = 8'h07;
    start_copy(4'b0000, 4'b0000);
    access(1'b0, 8'h07, 8'h00, rd, nst);
    finish_copy("R9 held request");
    chk("R9 held read data", rd, host_byte(8'h07));
    chk("R9 accepted on release", (nst > 0) && done_seen, 1'b1);
  endtask

  task automatic t_mem_access;
    logic [7:0] rd; int nst, tx;
    dly = 1;
    start_copy(4'b0101, 4'b0101); finish_copy("sw5 for access");
    @(negedge clk);
    tx = ext_txn;
    access(1'b1, 8'h30, 8'h99, rd, nst);
    chk("R6 write no stall", nst, 0);
    chk("R6 write reached ram", mem[8'h30], 8'h99);
    access(1'b0, 8'h30, 8'h00, rd, nst);
    chk("R6 read back", rd, 8'h99);
    access(1'b0, 8'hD3, 8'h00, rd, nst);
    chk("R6 read non-io top page", rd, host_byte(8'hD3));
    chk("R6 no external traffic", ext_txn, tx);
  endtask

  task automatic t_io_access;
    logic [7:0] rd; int nst, tx, wl;
    dly = 2;
    @(negedge clk);
    tx = ext_txn;
    access(1'b0, 8'hC3, 8'h00, rd, nst);
    chk("R7 io read data", rd, io_byte(8'hC3));
    chk("R7 io read stalled", nst >= 1, 1'b1);
    chk("R7 one external transfer", ext_txn, tx + 1);
    wl = wr_log_cnt;
    access(1'b1, 8'hE4, 8'h3C, rd, nst);
    chk("R7 io write forwarded", wr_log_cnt, wl + 1);
    chk("R7 io write address", wr_log_addr, 8'hE4);
    chk("R7 io write data", wr_log_data, 8'h3C);
    chk("R7 io write not in ram", mem[8'hE4], 8'hEE);
  endtask

  initial begin
    t_reset();
    t_copy_maps();
    t_restart();
    t_collision();
    t_mem_access();
    t_io_access();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule